// File: doc/BRIEF.md
# Serial Page Load Buffer with Commit Detector

This block sits behind the decoder of a static serial memory port. That decoder turns the pin activity into single-cycle read-cycle and write-cycle events, and each write event carries one data bit. The block follows those events through a complete programming sequence. First comes a reset pattern, which also sets the write-enable latch. Next come sixteen serial address bits. Then come whole data bytes, which the block gathers into an eight-byte page buffer. The sequence ends with a commit pattern. When the commit is accepted, the block copies the loaded bytes into the array through a write strobe interface. It then holds a busy flag for a modelled programming time that is set by a parameter.

The page is aligned on eight bytes. The low three address bits choose the slot where loading starts. Loading that runs past the last slot wraps back to slot 0. Any sequence that is partial or broken is thrown away without touching the array.

The sequencer has seven named states:

- `ST_IDLE` waits for a reset pattern.
- `ST_SYNC` expects the trailing read of the reset pattern.
- `ST_ADDR` shifts in the address.
- `ST_DATA` loads data bits.
- `ST_ARM` is entered after the read that closes the load.
- `ST_FIRE` is entered after the write-1 of the commit pattern.
- `ST_PROG` covers the busy time.

The transitions between them are these:

- Reset hit: any state except `ST_ADDR` and `ST_PROG` goes to `ST_SYNC`.
- `ST_SYNC` goes to `ST_ADDR` on a read and to `ST_IDLE` on a write.
- `ST_ADDR` goes to `ST_IDLE` on a read and to `ST_DATA` on its sixteenth bit.
- `ST_DATA` goes to `ST_ARM` on a read.
- `ST_ARM` goes to `ST_FIRE` on a write of 1.
- `ST_FIRE` goes to `ST_PROG` on a read when the commit is valid, and to `ST_IDLE` otherwise or on a write.
- `ST_PROG` goes to `ST_IDLE` when the busy count ends.

Top module: `page_loader`

## Requirements
- R1: During and just after reset, `busy` is 0 and `arr_we` is 0.
- R2: The reset pattern resets the sequence and sets the write-enable latch. The pattern is a read event followed immediately by a write event with bit 0, and it is accepted in any state except address loading and programming. One further read is expected after it. The next 16 write events are the address, most significant bit first. Only the low 9 bits are used: bits 8..3 give the page and bits 2..0 give the starting slot.
- R3: Data bits arrive most significant bit first. Each group of 8 bits forms one byte. The bytes fill the slots in order, beginning at the starting slot and wrapping from slot 7 to slot 0. A byte in slot s is written to array address {page, s}.
- R4: When more than 8 bytes are loaded, the later bytes overwrite the earlier bytes in the same slots.
- R5: The commit pattern is read, write of 1, read. When it is accepted, one `arr_we` pulse is produced for each slot that was loaded, in ascending slot order from 0 to 7. Slots that were not loaded produce no pulse.
- R6: No programming starts, and `busy` stays 0, in two cases: the number of data bits is not a multiple of 8, or no byte was loaded.
- R7: A read event during address loading abandons the sequence. A later commit pattern then produces no array write.
- R8: `busy` rises on the cycle after the accepted commit read. It stays high for exactly `BUSY_CYCLES` clock cycles.
- R9: While `busy` is high, all events are ignored, including a reset pattern. When programming completes, the write-enable latch is cleared and the sequencer returns to idle, so a commit pattern without a fresh reset pattern does nothing.
- R10: A reset pattern in the middle of a data load throws away the bytes loaded so far. Only the bytes of the new sequence are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_evt | input | 1 | One-cycle strobe marking a decoded read cycle |
| wr_evt | input | 1 | One-cycle strobe marking a decoded write cycle |
| wr_bit | input | 1 | Data bit carried by a write cycle |
| busy | output | 1 | High while programming is modelled |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 9 | Array byte address of the strobe |
| arr_data | output | 8 | Byte to write |

## Verification
The hardest case to reach from the ports is a reset pattern that arrives while programming is in progress. In that case a complete new sequence must change neither the array nor the busy timing. The stimulus commits one page and then, without waiting, sends a whole reset, address, byte and commit sequence inside the busy window. The scoreboard then confirms that only the first page's strobes appear. Two other sequences are driven to the commit pattern: one with partial bits, and one broken by a stray read during the address. Both must produce no strobe and no busy.

// File: rtl/pgld_pkg.sv
package pgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ADDR,
        ST_DATA,
        ST_ARM,
        ST_FIRE,
        ST_PROG
    } pg_state_e;

endpackage

// File: rtl/pgld_fsm.sv
module pgld_fsm
    import pgld_pkg::*;
#(
    parameter int ADDR_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_evt,
    input  logic wr_evt,
    input  logic wr_bit,
    input  logic commit_ok,
    input  logic prog_done,
    output logic seq_clr,
    output logic addr_shift,
    output logic data_shift,
    output logic prog_start
);

    localparam int ACNT_W = $clog2(ADDR_BITS + 1);

    pg_state_e state_q, state_d;
    logic [ACNT_W-1:0] addr_cnt_q;
    logic last_rd_q;
    logic wel_q;
    logic ev_rd, ev_wr, reset_hit, addr_last;

    // Simultaneous read and write strobes are meaningless and dropped.
    assign ev_rd = rd_evt & ~wr_evt;
    assign ev_wr = wr_evt & ~rd_evt;
    assign addr_last = (addr_cnt_q == ACNT_W'(ADDR_BITS - 1));
    assign reset_hit = ev_wr & ~wr_bit & last_rd_q &
                       (state_q != ST_ADDR) & (state_q != ST_PROG);

    always_comb begin
        state_d = state_q;
        if (reset_hit) begin
            state_d = ST_SYNC;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SYNC: begin
                    if (ev_rd) state_d = ST_ADDR;
                    else if (ev_wr) state_d = ST_IDLE;
                end
                ST_ADDR: begin
                    if (ev_rd) state_d = ST_IDLE;
                    else if (ev_wr && addr_last) state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (ev_rd) state_d = ST_ARM;
                end
                ST_ARM: begin
                    if (ev_wr && wr_bit) state_d = ST_FIRE;
                end
                ST_FIRE: begin
                    if (ev_rd) state_d = (commit_ok && wel_q) ? ST_PROG : ST_IDLE;
                    else if (ev_wr) state_d = ST_IDLE;
                end
                ST_PROG: begin
                    if (prog_done) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        seq_clr    = reset_hit;
        addr_shift = (state_q == ST_ADDR) & ev_wr;
        data_shift = (state_q == ST_DATA) & ev_wr;
        prog_start = (state_q == ST_FIRE) & ev_rd & commit_ok & wel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_cnt_q <= '0;
            last_rd_q  <= 1'b0;
            wel_q      <= 1'b0;
        end else begin
            if (state_q == ST_PROG) last_rd_q <= 1'b0;
            else if (ev_rd)         last_rd_q <= 1'b1;
            else if (ev_wr)         last_rd_q <= 1'b0;

            if (reset_hit)       addr_cnt_q <= '0;
            else if (addr_shift) addr_cnt_q <= addr_cnt_q + 1'b1;

            if (prog_done)      wel_q <= 1'b0;
            else if (reset_hit) wel_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pgld_buf.sv
module pgld_buf #(
    parameter int ADDR_BITS  = 16,
    parameter int ARR_AW     = 9,
    parameter int PAGE_BYTES = 8,
    parameter int BYTE_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic addr_shift,
    input  logic data_shift,
    input  logic bit_in,
    output logic [ARR_AW-$clog2(PAGE_BYTES)-1:0]  page_base,
    output logic [PAGE_BYTES-1:0][BYTE_W-1:0]     page_data,
    output logic [PAGE_BYTES-1:0]                 page_mask,
    output logic                                  commit_ok
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int BIT_W  = $clog2(BYTE_W);

    logic [ADDR_BITS-1:0] addr_sr_q;
    logic [BIT_W-1:0]     bit_idx_q;
    logic [SLOT_W-1:0]    byte_idx_q;
    logic [BYTE_W-1:0]    cur_q;
    logic [SLOT_W-1:0]    ptr;
    logic                 byte_done;
    logic [BYTE_W-1:0]    byte_full;

    assign ptr       = addr_sr_q[SLOT_W-1:0] + byte_idx_q;
    assign byte_done = data_shift && (bit_idx_q == BIT_W'(BYTE_W - 1));
    assign byte_full = {cur_q[BYTE_W-2:0], bit_in};
    assign page_base = addr_sr_q[ARR_AW-1:SLOT_W];
    assign commit_ok = (bit_idx_q == '0) && (|page_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sr_q  <= '0;
            bit_idx_q  <= '0;
            byte_idx_q <= '0;
            cur_q      <= '0;
        end else if (clr) begin
            bit_idx_q  <= '0;
            byte_idx_q <= '0;
            cur_q      <= '0;
        end else begin
            if (addr_shift) addr_sr_q <= {addr_sr_q[ADDR_BITS-2:0], bit_in};
            if (data_shift) begin
                cur_q     <= byte_full;
                bit_idx_q <= byte_done ? '0 : bit_idx_q + 1'b1;
                if (byte_done) byte_idx_q <= byte_idx_q + 1'b1;
            end
        end
    end

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_data[s] <= '0;
                page_mask[s] <= 1'b0;
            end else if (clr) begin
                page_mask[s] <= 1'b0;
            end else if (byte_done && ptr == SLOT_W'(s)) begin
                page_data[s] <= byte_full;
                page_mask[s] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgld_prog.sv
module pgld_prog #(
    parameter int ARR_AW      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int BYTE_W      = 8,
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [ARR_AW-$clog2(PAGE_BYTES)-1:0] page_base,
    input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]    page_data,
    input  logic [PAGE_BYTES-1:0]                page_mask,
    output logic busy,
    output logic done,
    output logic arr_we,
    output logic [ARR_AW-1:0] arr_addr,
    output logic [BYTE_W-1:0] arr_data
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] slot;

    assign slot = cnt_q[SLOT_W-1:0];
    assign busy = active_q;
    assign done = active_q && (cnt_q == CNT_W'(BUSY_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (done) active_q <= 1'b0;
            else      cnt_q    <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_we   <= 1'b0;
            arr_addr <= '0;
            arr_data <= '0;
        end else begin
            arr_we   <= active_q && (cnt_q < CNT_W'(PAGE_BYTES)) && page_mask[slot];
            arr_addr <= {page_base, slot};
            arr_data <= page_data[slot];
        end
    end

endmodule

// File: rtl/page_loader.sv
module page_loader #(
    parameter int ADDR_BITS   = 16,
    parameter int ARR_AW      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int BYTE_W      = 8,
    parameter int BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_evt,
    input  logic              wr_evt,
    input  logic              wr_bit,
    output logic              busy,
    output logic              arr_we,
    output logic [ARR_AW-1:0] arr_addr,
    output logic [BYTE_W-1:0] arr_data
);

    localparam int PAGE_W = ARR_AW - $clog2(PAGE_BYTES);

    logic seq_clr, addr_shift, data_shift, prog_start, prog_done, commit_ok;
    logic [PAGE_W-1:0]                page_base;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_data;
    logic [PAGE_BYTES-1:0]            page_mask;

    pgld_fsm #(.ADDR_BITS(ADDR_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .wr_bit(wr_bit), .commit_ok(commit_ok), .prog_done(prog_done),
        .seq_clr(seq_clr), .addr_shift(addr_shift), .data_shift(data_shift),
        .prog_start(prog_start)
    );

    pgld_buf #(.ADDR_BITS(ADDR_BITS), .ARR_AW(ARR_AW),
               .PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(seq_clr), .addr_shift(addr_shift),
        .data_shift(data_shift), .bit_in(wr_bit), .page_base(page_base),
        .page_data(page_data), .page_mask(page_mask), .commit_ok(commit_ok)
    );

    pgld_prog #(.ARR_AW(ARR_AW), .PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W),
                .BUSY_CYCLES(BUSY_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .page_base(page_base),
        .page_data(page_data), .page_mask(page_mask), .busy(busy),
        .done(prog_done), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data)
    );

endmodule

// File: rtl/pgld_chk.sv
module pgld_chk #(
    parameter int ARR_AW      = 9,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_evt,
    input logic              busy,
    input logic              arr_we,
    input logic [ARR_AW-1:0] arr_addr
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int RUN_W  = $clog2(BUSY_CYCLES + 2) + 1;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R1: quiet outputs on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !arr_we));

    // R5: strobes only inside the busy window
    a_r5_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R5: consecutive strobes stay in one page with rising slot
    a_r5_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we) && $past(busy)) |->
        (arr_addr[ARR_AW-1:SLOT_W] == $past(arr_addr[ARR_AW-1:SLOT_W]) &&
         arr_addr[SLOT_W-1:0] > $past(arr_addr[SLOT_W-1:0])));

    // R6: programming begins only from a read event
    a_r6_start_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rd_evt));

    // R8: each busy window lasts exactly BUSY_CYCLES cycles
    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RUN_W'(BUSY_CYCLES)));

    // R9: no strobe after busy ends
    a_r9_no_late_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !arr_we);

endmodule

bind page_loader pgld_chk #(
    .ARR_AW(ARR_AW), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/sim_page_loader.sv
module sim_page_loader;

    localparam int BUSY = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_evt = 1'b0, wr_evt = 1'b0, wr_bit = 1'b0;
    logic busy, arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    logic [7:0] m_data [8];
    logic [7:0] m_mask;
    logic [2:0] m_start;
    logic [5:0] m_page;
    int         m_cnt;

    always #10 clk = ~clk;

    page_loader #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .wr_bit(wr_bit), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected strobes in order
    always @(negedge clk) begin
        if (rst_n && arr_we && !done_flag) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R6/R9 unexpected strobe", {arr_addr, arr_data}, 0);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({arr_addr, arr_data} == e, t, {arr_addr, arr_data}, e);
            end
        end
    end

    task automatic rd_cyc();
        rd_evt = 1'b1;
        @(negedge clk);
        rd_evt = 1'b0;
    endtask

    task automatic wr_cyc(input logic b);
        wr_evt = 1'b1;
        wr_bit = b;
        @(negedge clk);
        wr_evt = 1'b0;
        wr_bit = 1'b0;
    endtask

    task automatic begin_page(input logic [15:0] a);
        rd_cyc(); wr_cyc(1'b0); rd_cyc();
        for (int i = 15; i >= 0; i--) wr_cyc(a[i]);
        m_mask  = '0;
        m_start = a[2:0];
        m_page  = a[8:3];
        m_cnt   = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [2:0] s;
        s = m_start + 3'(m_cnt);
        m_data[s] = b;
        m_mask[s] = 1'b1;
        m_cnt++;
        for (int i = 7; i >= 0; i--) wr_cyc(b[i]);
    endtask

    task automatic commit(input bit expect_prog, input string tag);
        rd_cyc(); wr_cyc(1'b1); rd_cyc();
        if (expect_prog) begin
            for (int s = 0; s < 8; s++) begin
                if (m_mask[s]) begin
                    exp_q.push_back({m_page, 3'(s), m_data[s]});
                    tag_q.push_back(tag);
                end
            end
        end
        check(busy == expect_prog, {tag, " busy after commit"}, busy, expect_prog);
    endtask

    task automatic finish_prog(input bit chk_len, input string tag);
        int n;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        if (chk_len) check(n == BUSY, "R8 busy length", n, BUSY);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all strobes seen"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            done_flag = 1;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R1 reset state", {busy, arr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R1 after release", {busy, arr_we}, 0);

        // R2 R3 R5 R8: full page from slot 0
        begin_page(16'h0028);
        for (int i = 0; i < 8; i++) send_byte(8'hA0 + 8'(i * 7));
        commit(1'b1, "R3 full page");
        finish_prog(1'b1, "R5 full page");

        // R2 R3: don't-care upper bits, start slot 5, wrap
        begin_page(16'hFE00 | 16'h01F5);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_byte(8'h44); send_byte(8'h55);
        commit(1'b1, "R2 R3 wrap page");
        finish_prog(1'b1, "R5 loaded slots only");

        // R4: ten bytes overwrite
        begin_page(16'h0062);
        for (int i = 0; i < 10; i++) send_byte(8'h30 + 8'(i));
        commit(1'b1, "R4 overwrite");
        finish_prog(1'b1, "R4 overwrite");

        // R6: partial bit count
        begin_page(16'h0010);
        send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h0F);
        for (int i = 0; i < 5; i++) wr_cyc(1'b1);
        commit(1'b0, "R6 partial bits");
        finish_prog(1'b0, "R6 partial bits");

        // R6: no data at all
        begin_page(16'h0040);
        commit(1'b0, "R6 zero bytes");
        finish_prog(1'b0, "R6 zero bytes");

        // R7: read inside address aborts
        rd_cyc(); wr_cyc(1'b0); rd_cyc();
        for (int i = 0; i < 8; i++) wr_cyc(1'b1);
        rd_cyc();
        for (int i = 0; i < 8; i++) wr_cyc(1'b1);
        for (int i = 0; i < 16; i++) wr_cyc(i[0]);
        commit(1'b0, "R7 aborted address");
        finish_prog(1'b0, "R7 aborted address");

        // R9: full sequence during busy is ignored
        begin_page(16'h0118);
        send_byte(8'h9E); send_byte(8'h7D);
        commit(1'b1, "R9 first page");
        rd_cyc(); wr_cyc(1'b0); rd_cyc();
        for (int i = 15; i >= 0; i--) wr_cyc(i[1]);
        for (int i = 0; i < 8; i++) wr_cyc(1'b1);
        rd_cyc(); wr_cyc(1'b1); rd_cyc();
        check(busy == 1'b1, "R9 still busy", busy, 1);
        finish_prog(1'b0, "R9 ignore while busy");

        // R9: commit without fresh reset pattern
        commit(1'b0, "R9 no reset");
        finish_prog(1'b0, "R9 no reset");

        // R10: reset pattern mid load discards bytes
        begin_page(16'h0080);
        send_byte(8'hEE); send_byte(8'hDD); send_byte(8'hCC);
        begin_page(16'h0086);
        send_byte(8'h12); send_byte(8'h34);
        commit(1'b1, "R10 restart");
        finish_prog(1'b1, "R10 restart");

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule